// File: doc/BRIEF.md
# Atomic 64-bit Compare-Exchange Bus Sequencer

This block carries out one atomic compare-and-exchange of a 64-bit word in memory over a simple bus with a lock line. A caller supplies a word address, an expected value given as two 32-bit halves, a replacement value given the same way, and a lock-mode bit. It then pulses `start`. The sequencer reads the target word, compares it with the expected value and always follows with a write to the same address. The write carries the replacement value when the compare matches, and the unchanged word when it does not. A read is therefore never left without a paired write.

When the sequence finishes, the block pulses `done`. It reports an equal flag and the updated expected value. That value is the caller's own value on a match, and on a mismatch it is the word found in memory. In lock mode the bus lock line covers both transfers without a break. Each bus transfer holds its strobe until the responder answers with `bus_rdy`.

Top module: `cmpxchg64_seq`

## Requirements
- R1: The 64-bit expected value is {exp_hi, exp_lo} and the replacement is {new_hi, new_lo}, with the `_hi` half in bits 63:32. `bus_wdata` and `bus_rdata` use the same packing, and a difference in either half alone makes the compare fail.
- R2: When the word read equals the expected value, `zf` is 1 and the word at the address becomes the replacement value.
- R3: When they differ, `zf` is 0 and {res_hi, res_lo} returns the word read. The word is written back unchanged, so memory keeps its value.
- R4: Every accepted start produces exactly one read followed by exactly one write, both to the latched address. The write happens whether or not the compare matched.
- R5: With `lock_en` = 1 at start, `bus_lock` rises in the cycle after the accepted start, before the read strobe. It stays high continuously through the write and falls in the cycle after the write's `bus_rdy`.
- R6: With `lock_en` = 0 at start, `bus_lock` stays low for the whole sequence, while the read and the write still take place.
- R7: `done` is high for exactly one cycle, the cycle after the write's `bus_rdy`. `zf` and the result are valid in that cycle and hold until the next sequence completes.
- R8: `busy` is 1 from the cycle after an accepted start until the cycle of `done`, where it is 0. A `start` while `busy` is high is ignored, together with its operands.
- R9: Each transfer holds `bus_rd` or `bus_wr` high until `bus_rdy` is seen with it. Any number of wait cycles is allowed, including none.
- R10: `bus_rd` and `bus_wr` are never high together. No strobe and no lock is driven while idle.
- R11: After reset, `busy`, `done`, `bus_rd`, `bus_wr`, `bus_lock` and `zf` are 0 and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted when not busy) |
| lock_en | input | 1 | Run the sequence with the bus lock asserted |
| addr | input | ADDR_W | Word address of the target |
| exp_hi | input | HALF_W | Expected value, upper half |
| exp_lo | input | HALF_W | Expected value, lower half |
| new_hi | input | HALF_W | Replacement value, upper half |
| new_lo | input | HALF_W | Replacement value, lower half |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | 1 when the compare matched |
| res_hi | output | HALF_W | Updated expected value, upper half |
| res_lo | output | HALF_W | Updated expected value, lower half |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_lock | output | 1 | Bus lock line |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | 2*HALF_W | Write data |
| bus_rdata | input | 2*HALF_W | Read data, valid with bus_rdy during a read |
| bus_rdy | input | 1 | Transfer acknowledge |

## Verification
The bench builds the block with HALF_W = 32 and ADDR_W = 4. The full 64-bit compare width is therefore exercised, including mismatches confined to one half. The 16-word space makes random addresses hit the same word again, so words already swapped are compared once more. A responder with latency from zero up to twelve cycles reaches both the back-to-back acknowledge path and long strobe holds. Starts held high through a busy sequence with changing operands show that they are ignored.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_READ_REQ   = 3'd1,
    ST_READ_WAIT  = 3'd2,
    ST_COMPARE    = 3'd3,
    ST_WRITE_REQ  = 3'd4,
    ST_WRITE_WAIT = 3'd5,
    ST_DONE       = 3'd6
  } cx_state_t;
endpackage

// File: rtl/cx_ctrl.sv
module cx_ctrl
  import cx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      bus_rdy,
  output cx_state_t state,
  output logic      accept,
  output logic      rd_ack,
  output logic      wr_ack,
  output logic      busy,
  output logic      done
);
  cx_state_t nxt;

  assign accept = start && (state == ST_IDLE || state == ST_DONE);
  assign rd_ack = (state == ST_READ_WAIT) && bus_rdy;
  assign wr_ack = (state == ST_WRITE_WAIT) && bus_rdy;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:       if (accept) nxt = ST_READ_REQ;
      ST_READ_REQ:   nxt = ST_READ_WAIT;
      ST_READ_WAIT:  if (rd_ack) nxt = ST_COMPARE;
      ST_COMPARE:    nxt = ST_WRITE_REQ;
      ST_WRITE_REQ:  nxt = ST_WRITE_WAIT;
      ST_WRITE_WAIT: if (wr_ack) nxt = ST_DONE;
      ST_DONE:       nxt = accept ? ST_READ_REQ : ST_IDLE;
      default:       nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= wr_ack;
      if (accept)      busy <= 1'b1;
      else if (wr_ack) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cx_bus.sv
module cx_bus
  import cx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  cx_state_t         state,
  input  logic              accept,
  input  logic              rd_ack,
  input  logic              wr_ack,
  input  logic              lock_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_lock,
  output logic [ADDR_W-1:0] bus_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd   <= 1'b0;
      bus_wr   <= 1'b0;
      bus_lock <= 1'b0;
      bus_addr <= '0;
    end else begin
      if (accept) begin
        bus_addr <= addr;
        bus_lock <= lock_en;
      end else if (wr_ack) begin
        bus_lock <= 1'b0;
      end

      if (state == ST_READ_REQ) bus_rd <= 1'b1;
      else if (rd_ack)          bus_rd <= 1'b0;

      if (state == ST_WRITE_REQ) bus_wr <= 1'b1;
      else if (wr_ack)           bus_wr <= 1'b0;
    end
  end
endmodule

// File: rtl/cx_cmp.sv
module cx_cmp #(
  parameter int HALF_W = 32,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              rd_ack,
  input  logic              cmp_en,
  input  logic              wr_ack,
  input  logic [HALF_W-1:0] exp_hi,
  input  logic [HALF_W-1:0] exp_lo,
  input  logic [HALF_W-1:0] new_hi,
  input  logic [HALF_W-1:0] new_lo,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] wdata,
  output logic              zf,
  output logic [WORD_W-1:0] res
);
  logic [WORD_W-1:0] exp_q, new_q, old_q;
  logic              eq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q <= '0;
      new_q <= '0;
      old_q <= '0;
      eq_q  <= 1'b0;
      wdata <= '0;
      zf    <= 1'b0;
      res   <= '0;
    end else begin
      if (accept) begin
        exp_q <= {exp_hi, exp_lo};
        new_q <= {new_hi, new_lo};
      end
      if (rd_ack) old_q <= rdata;
      if (cmp_en) begin
        eq_q  <= (old_q == exp_q);
        wdata <= (old_q == exp_q) ? new_q : old_q;
      end
      if (wr_ack) begin
        zf  <= eq_q;
        res <= eq_q ? exp_q : old_q;
      end
    end
  end
endmodule

// File: rtl/cmpxchg64_seq.sv
module cmpxchg64_seq
  import cx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 32,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              lock_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] exp_hi,
  input  logic [HALF_W-1:0] exp_lo,
  input  logic [HALF_W-1:0] new_hi,
  input  logic [HALF_W-1:0] new_lo,
  output logic              busy,
  output logic              done,
  output logic              zf,
  output logic [HALF_W-1:0] res_hi,
  output logic [HALF_W-1:0] res_lo,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_lock,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_rdy
);
  cx_state_t         state;
  logic              accept, rd_ack, wr_ack;
  logic [WORD_W-1:0] res_w;

  cx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .bus_rdy(bus_rdy),
    .state(state), .accept(accept), .rd_ack(rd_ack), .wr_ack(wr_ack),
    .busy(busy), .done(done)
  );

  cx_bus #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .state(state), .accept(accept),
    .rd_ack(rd_ack), .wr_ack(wr_ack), .lock_en(lock_en), .addr(addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_lock(bus_lock), .bus_addr(bus_addr)
  );

  cx_cmp #(.HALF_W(HALF_W)) u_cmp (
    .clk(clk), .rst(rst), .accept(accept), .rd_ack(rd_ack),
    .cmp_en(state == ST_COMPARE), .wr_ack(wr_ack),
    .exp_hi(exp_hi), .exp_lo(exp_lo), .new_hi(new_hi), .new_lo(new_lo),
    .rdata(bus_rdata), .wdata(bus_wdata), .zf(zf), .res(res_w)
  );

  assign res_hi = res_w[WORD_W-1:HALF_W];
  assign res_lo = res_w[HALF_W-1:0];
endmodule

// File: rtl/cx_chk.sv
module cx_chk #(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              zf,
  input logic [HALF_W-1:0] res_hi,
  input logic [HALF_W-1:0] res_lo,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_rdy,
  input logic              bus_lock
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_rd && !bus_wr && !bus_lock);

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_rdy |=> busy && !done);

  // R5
  lock_release_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_rdy |=> !bus_lock && done);

  // R5
  lock_steady_chk: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(bus_lock));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> $stable(zf) && $stable(res_hi) && $stable(res_lo));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start && !(bus_wr && bus_rdy) |=> busy);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !bus_rdy |=> bus_rd);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !bus_rdy |=> bus_wr);
endmodule

bind cmpxchg64_seq cx_chk #(.HALF_W(HALF_W)) i_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .zf(zf),
  .res_hi(res_hi), .res_lo(res_lo), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdy(bus_rdy), .bus_lock(bus_lock)
);

// File: tb/test_cmpxchg64_seq.sv
module test_cmpxchg64_seq;
  localparam int ADDR_W = 4;
  localparam int HALF_W = 32;
  localparam int WORD_W = 2 * HALF_W;
  localparam int NWORDS = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              lock_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [HALF_W-1:0] exp_hi = '0, exp_lo = '0, new_hi = '0, new_lo = '0;
  logic              busy, done, zf;
  logic [HALF_W-1:0] res_hi, res_lo;
  logic              bus_rd, bus_wr, bus_lock;
  logic [ADDR_W-1:0] bus_addr;
  logic [WORD_W-1:0] bus_wdata;
  logic [WORD_W-1:0] bus_rdata = '0;
  logic              bus_rdy = 1'b0;

  cmpxchg64_seq #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) i_cmpxchg64_seq (
    .clk(clk), .rst(rst), .start(start), .lock_en(lock_en), .addr(addr),
    .exp_hi(exp_hi), .exp_lo(exp_lo), .new_hi(new_hi), .new_lo(new_lo),
    .busy(busy), .done(done), .zf(zf), .res_hi(res_hi), .res_lo(res_lo),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_lock(bus_lock), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;

  // responder state
  logic [WORD_W-1:0] mem [NWORDS];
  logic [WORD_W-1:0] mdl [NWORDS];
  int wmax = 3;
  int lat = 0;
  int wcnt = 0;
  int rd_total = 0, wr_total = 0, order_bad = 0, both_bad = 0;
  logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;

  always @(posedge clk) begin
    if (rst) begin
      bus_rdy <= 1'b0;
      wcnt    <= 0;
    end else if (bus_rdy) begin
      bus_rdy <= 1'b0;
    end else if (bus_rd || bus_wr) begin
      if (bus_rd && bus_wr) both_bad <= both_bad + 1;
      if (wcnt >= lat) begin
        bus_rdy <= 1'b1;
        wcnt    <= 0;
        lat     <= $urandom_range(0, wmax);
        if (bus_rd) begin
          bus_rdata <= mem[bus_addr];
          rd_addr   <= bus_addr;
          rd_total  <= rd_total + 1;
        end else begin
          mem[bus_addr] <= bus_wdata;
          wr_addr       <= bus_addr;
          if (rd_total != wr_total + 1) order_bad <= order_bad + 1;
          wr_total      <= wr_total + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [WORD_W-1:0] mem_after(input logic [WORD_W-1:0] old,
      input logic [WORD_W-1:0] ev, input logic [WORD_W-1:0] nv);
    return (old == ev) ? nv : old;
  endfunction

  task automatic run_op(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] ev,
                        input logic [WORD_W-1:0] nv, input bit lk, input bit spam);
    logic [WORD_W-1:0] old, exp_m, exp_r;
    bit   exp_z, gap;
    int   rd0, wr0, cyc;
    old   = mdl[a];
    exp_z = (old == ev);
    exp_m = mem_after(old, ev, nv);
    exp_r = old;
    rd0 = rd_total; wr0 = wr_total;
    gap = 1'b0;
    @(negedge clk);
    start = 1'b1; lock_en = lk; addr = a;
    {exp_hi, exp_lo} = ev; {new_hi, new_lo} = nv;
    @(negedge clk);
    check(busy == 1'b1, "R8 busy after start", {63'b0, busy}, 64'd1);
    check(bus_lock == lk && !bus_rd, "R5 R6 lock before read", {63'b0, bus_lock}, {63'b0, lk});
    if (spam) begin
      addr = a + 1'b1; lock_en = ~lk;
      {exp_hi, exp_lo} = ~ev; {new_hi, new_lo} = ~nv;
    end else begin
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 200) begin
      if (bus_lock !== lk) gap = 1'b1;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done == 1'b1, "R7 done seen", {63'b0, done}, 64'd1);
    check(!gap, "R5 R6 lock level through sequence", {63'b0, gap}, 64'd0);
    check(!bus_lock && !busy, "R5 R8 lock and busy low at done", {62'b0, bus_lock, busy}, 64'd0);
    check(zf == exp_z, "R2 R3 zf", {63'b0, zf}, {63'b0, exp_z});
    check({res_hi, res_lo} == exp_r, "R3 R1 result value", {res_hi, res_lo}, exp_r);
    check(rd_total - rd0 == 1 && wr_total - wr0 == 1, "R4 one read one write",
          64'(rd_total - rd0) << 8 | 64'(wr_total - wr0), 64'h101);
    check(rd_addr == a && wr_addr == a, "R4 address", {56'b0, rd_addr, wr_addr}, {56'b0, a, a});
    check(mem[a] == exp_m, "R2 R3 memory word", mem[a], exp_m);
    mdl[a] = exp_m;
    @(negedge clk);
    check(!done, "R7 done single cycle", {63'b0, done}, 64'd0);
    check(zf == exp_z && {res_hi, res_lo} == exp_r, "R7 result held", {res_hi, res_lo}, exp_r);
  endtask

  initial begin
    logic [WORD_W-1:0] w;
    void'($urandom(32'd7741));
    for (int i = 0; i < NWORDS; i++) begin
      w = {$urandom(), $urandom()};
      mem[i] = w;
      mdl[i] = w;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    check(!busy && !done && !bus_rd && !bus_wr && !bus_lock && !zf && {res_hi, res_lo} == '0,
          "R11 reset state", {res_hi, res_lo}, 64'd0);

    // directed: match with lock (R2, R5)
    run_op(4'd2, mdl[2], 64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0);
    // mismatch in low half only (R1, R3)
    run_op(4'd3, mdl[3] ^ 64'h1, 64'h1111_1111_1111_1111, 1'b1, 1'b0);
    // mismatch in high half only (R1, R3)
    run_op(4'd4, mdl[4] ^ 64'h8000_0000_0000_0000, 64'h2222_2222_2222_2222, 1'b1, 1'b0);
    // lock off (R6)
    run_op(4'd5, mdl[5], 64'h3333_4444_5555_6666, 1'b0, 1'b0);
    // zero latency (R9)
    wmax = 0;
    run_op(4'd6, mdl[6], 64'h0, 1'b1, 1'b0);
    run_op(4'd6, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    // long latency (R9)
    wmax = 12;
    run_op(4'd7, mdl[7], 64'h7777_0000_7777_0000, 1'b1, 1'b0);
    // start held during busy with other operands (R8)
    wmax = 3;
    run_op(4'd8, mdl[8], 64'hABCD_ABCD_ABCD_ABCD, 1'b1, 1'b1);
    run_op(4'd9, mdl[9] ^ 64'h10, 64'h5, 1'b0, 1'b1);

    // random mix
    for (int k = 0; k < 200; k++) begin
      logic [ADDR_W-1:0] ra;
      logic [WORD_W-1:0] rev;
      ra  = ADDR_W'($urandom_range(0, NWORDS - 1));
      rev = ($urandom_range(0, 1) == 1) ? mdl[ra] : {$urandom(), $urandom()};
      wmax = $urandom_range(0, 5);
      run_op(ra, rev, {$urandom(), $urandom()}, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 3) == 0));
    end

    // R10 R4
    check(both_bad == 0, "R10 strobes exclusive", 64'(both_bad), 64'd0);
    check(order_bad == 0, "R4 read before write", 64'(order_bad), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule